// File: doc/BRIEF.md
# Width-Parameterised Adder/Subtractor with Carry and Borrow

This block is a purely combinational two's-complement arithmetic unit. It takes two operands of a width the instantiating module chooses, one carry bit and a mode bit. In add mode it produces the sum of both operands and the carry bit. In subtract mode it produces the first operand minus the second. The carry bit then acts as an active-low borrow: a high carry gives the plain difference, and a low carry takes one more away.

The datapath is a ripple chain of full-adder stages. Subtraction reuses the same chain. Every bit of the second operand is inverted when subtract mode is selected, and the carry bit enters stage 0 unchanged. The chain therefore computes A + ~B + carry. Three outputs come from the chain: the result word, the carry out of the top stage, and a signed overflow flag.

Because each carry out and carry in is a plain bit, several units can be cascaded or fed from a flag register. No clock or reset reaches the block. Its outputs follow its inputs within the same evaluation.

Top module: `arith_addsub`

## Requirements
- R1: With `add_mode` = 1, `result` equals (op_a + op_b + carry_in) modulo 2^WIDTH.
- R2: With `add_mode` = 0, `result` equals (op_a − op_b + carry_in − 1) modulo 2^WIDTH. carry_in = 1 gives the plain difference and carry_in = 0 subtracts one more.
- R3: With `add_mode` = 1, `carry_out` equals bit WIDTH of the unsigned sum op_a + op_b + carry_in.
- R4: With `add_mode` = 0, `carry_out` is 1 exactly when no borrow occurs. In unsigned terms, that is when op_a ≥ op_b + (1 − carry_in).
- R5: `overflow` is 1 exactly when the exact signed value, with the operands read as two's-complement numbers, falls outside [−2^(WIDTH−1), 2^(WIDTH−1) − 1]. The exact signed value is op_a + op_b + carry_in in add mode and op_a − op_b + carry_in − 1 in subtract mode.
- R6: In subtract mode with op_a equal to op_b, carry_in = 1 gives `result` all zeros and `carry_out` = 1. carry_in = 0 gives `result` all ones and `carry_out` = 0. `overflow` is 0 in both cases.
- R7: The behaviour of R1 to R5 holds for any WIDTH ≥ 1 set at instantiation, including a narrow width of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand (minuend in subtract mode) |
| op_b | input | WIDTH | Second operand (subtrahend in subtract mode) |
| carry_in | input | 1 | Carry into bit 0; active-low borrow in subtract mode |
| add_mode | input | 1 | 1 selects addition, 0 selects subtraction |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top stage; in subtract mode, 1 means no borrow |
| overflow | output | 1 | Signed overflow of the operation |

## Verification
The block holds no state, so any fault in a stage shows at the ports in the same evaluation in which its inputs arrive. A wrong carry from stage i corrupts `result` from bit i+1 upward, and it reaches `carry_out` when it propagates through the upper bits. A fault in the top two carries also flips `overflow`. A fault in the operand inversion shows only in subtract mode, which is why both modes are checked against the exact integer value on every cycle. Long carry propagation, such as all-ones plus one and equal operands in subtract mode, is checked on its own so that a broken link in the chain appears as a wrong top bit.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic {
    OP_SUB = 1'b0,
    OP_ADD = 1'b1
  } op_mode_e;

  typedef struct packed {
    logic sum;
    logic cout;
  } fa_out_t;

  function automatic fa_out_t full_add(input logic x, input logic y, input logic c);
    fa_out_t r;
    r.sum  = x ^ y ^ c;
    r.cout = (x & y) | (x & c) | (y & c);
    return r;
  endfunction

endpackage

// File: rtl/as_fa_cell.sv
module as_fa_cell
  import addsub_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  fa_out_t res;

  always_comb begin
    res = full_add(x_i, y_i, c_i);
  end

  assign s_o = res.sum;
  assign c_o = res.cout;

endmodule

// File: rtl/as_operand_cond.sv
module as_operand_cond #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             invert_i,
  output logic [WIDTH-1:0] b_eff_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign b_eff_o[g] = b_i[g] ^ invert_i;
  end

endmodule

// File: rtl/as_ripple_chain.sv
module as_ripple_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c0_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_top_in_o,
  output logic             c_top_out_o
);

  localparam int NCARRY = WIDTH + 1;

  logic [NCARRY-1:0] carry;

  assign carry[0] = c0_i;

  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    as_fa_cell u_cell (
      .x_i (a_i[g]),
      .y_i (b_i[g]),
      .c_i (carry[g]),
      .s_o (sum_o[g]),
      .c_o (carry[g+1])
    );
  end

  assign c_top_in_o  = carry[WIDTH-1];
  assign c_top_out_o = carry[WIDTH];

endmodule

// File: rtl/as_status_flags.sv
module as_status_flags (
  input  logic c_msb_in_i,
  input  logic c_msb_out_i,
  output logic carry_o,
  output logic ovf_o
);

  assign carry_o = c_msb_out_i;
  assign ovf_o   = c_msb_in_i ^ c_msb_out_i;

endmodule

// File: rtl/arith_addsub.sv
module arith_addsub
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  input  logic             add_mode,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow
);

  op_mode_e          mode_sel;
  logic              invert_b;
  logic [WIDTH-1:0]  b_eff;
  logic              c_top_in;
  logic              c_top_out;

  always_comb begin
    mode_sel = op_mode_e'(add_mode);
    invert_b = (mode_sel == OP_SUB);
  end

  as_operand_cond #(.WIDTH(WIDTH)) u_cond (
    .b_i      (op_b),
    .invert_i (invert_b),
    .b_eff_o  (b_eff)
  );

  as_ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i         (op_a),
    .b_i         (b_eff),
    .c0_i        (carry_in),
    .sum_o       (result),
    .c_top_in_o  (c_top_in),
    .c_top_out_o (c_top_out)
  );

  as_status_flags u_flags (
    .c_msb_in_i  (c_top_in),
    .c_msb_out_i (c_top_out),
    .carry_o     (carry_out),
    .ovf_o       (overflow)
  );

endmodule

// File: rtl/arith_addsub_chk.sv
module arith_addsub_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic             add_mode,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             overflow
);

  localparam int XW = WIDTH + 2;

  logic [WIDTH:0]          wide_sum;
  logic [WIDTH:0]          need;
  logic [WIDTH-1:0]        diff;
  logic signed [XW-1:0]    sa;
  logic signed [XW-1:0]    sb;
  logic signed [XW-1:0]    sx;
  logic                    ovf_exp;
  logic                    known;

  always_comb begin
    known    = !$isunknown({op_a, op_b, carry_in, add_mode, result, carry_out, overflow});
    wide_sum = {1'b0, op_a} + {1'b0, op_b} + (WIDTH+1)'(carry_in);
    need     = {1'b0, op_b} + (WIDTH+1)'(!carry_in);
    diff     = op_a - op_b - WIDTH'(!carry_in);
    sa       = XW'($signed(op_a));
    sb       = XW'($signed(op_b));
    if (add_mode) sx = sa + sb + XW'(carry_in);
    else          sx = sa - sb + XW'(carry_in) - XW'(1);
    ovf_exp  = !((&sx[XW-1:WIDTH-1]) || !(|sx[XW-1:WIDTH-1]));

    if (known) begin
      // R1
      add_sum_chk: assert (!add_mode || result == wide_sum[WIDTH-1:0])
        else $error("add result mismatch");
      // R2
      sub_diff_chk: assert (add_mode || result == diff)
        else $error("sub result mismatch");
      // R3
      add_carry_chk: assert (!add_mode || carry_out == wide_sum[WIDTH])
        else $error("add carry mismatch");
      // R4
      sub_borrow_chk: assert (add_mode || carry_out == ({1'b0, op_a} >= need))
        else $error("sub borrow mismatch");
      // R5
      signed_ovf_chk: assert (overflow == ovf_exp)
        else $error("overflow mismatch");
      // R6
      equal_sub_chk: assert (add_mode || op_a != op_b ||
                             (carry_out == carry_in && result == {WIDTH{!carry_in}} && !overflow))
        else $error("equal-operand subtract mismatch");
    end
  end

endmodule

bind arith_addsub arith_addsub_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .carry_in  (carry_in),
  .add_mode  (add_mode),
  .result    (result),
  .carry_out (carry_out),
  .overflow  (overflow)
);

// File: tb/arith_addsub_test.sv
module arith_addsub_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] a8, b8, r8;
  logic       cin8, md8, c8, v8;
  logic [3:0] a4, b4, r4;
  logic       cin4, md4, c4, v4;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  arith_addsub #(.WIDTH(8)) uut (
    .op_a(a8), .op_b(b8), .carry_in(cin8), .add_mode(md8),
    .result(r8), .carry_out(c8), .overflow(v8)
  );

  arith_addsub #(.WIDTH(4)) uut_narrow (
    .op_a(a4), .op_b(b4), .carry_in(cin4), .add_mode(md4),
    .result(r4), .carry_out(c4), .overflow(v4)
  );

  task automatic cmp(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_vec(input int w, input longint a, input longint b, input bit cin,
                           input bit mode, input longint got_r, input bit got_c,
                           input bit got_v, input string tag);
    longint mask, half, tot, er, sa, sb, se;
    bit ec, ev;
    mask = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    if (mode) begin
      tot = a + b + cin;
      er  = tot & mask;
      ec  = tot > mask;
    end else begin
      tot = a - b + cin - 1;
      er  = tot & mask;
      ec  = tot >= 0;
    end
    sa = (a >= half) ? a - (mask + 1) : a;
    sb = (b >= half) ? b - (mask + 1) : b;
    se = mode ? sa + sb + cin : sa - sb + cin - 1;
    ev = (se >= half) || (se < -half);
    cmp(mode ? {"R1 result ", tag} : {"R2 result ", tag}, got_r, er);
    cmp(mode ? {"R3 carry ", tag}  : {"R4 carry ", tag},  longint'(got_c), longint'(ec));
    cmp({"R5 overflow ", tag}, longint'(got_v), longint'(ev));
  endtask

  task automatic run8(input logic [7:0] a, input logic [7:0] b, input bit cin,
                      input bit mode, input string tag);
    @(posedge clk);
    a8 = a; b8 = b; cin8 = cin; md8 = mode;
    @(negedge clk);
    check_vec(8, a, b, cin, mode, r8, c8, v8, tag);
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b, input bit cin,
                      input bit mode);
    @(posedge clk);
    a4 = a; b4 = b; cin4 = cin; md4 = mode;
    @(negedge clk);
    check_vec(4, a, b, cin, mode, r4, c4, v4, "R7 width4");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    a8 = '0; b8 = '0; cin8 = 1'b0; md8 = 1'b1;
    a4 = '0; b4 = '0; cin4 = 1'b0; md4 = 1'b1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // idle state: all zero inputs, add mode (R1)
    @(negedge clk);
    check_vec(8, 0, 0, 0, 1, r8, c8, v8, "idle");

    run8(8'h12, 8'h34, 1'b0, 1'b1, "basic add");
    run8(8'h12, 8'h34, 1'b1, 1'b1, "add with carry");
    run8(8'hFF, 8'h00, 1'b1, 1'b1, "R3 full carry ripple");
    run8(8'hFF, 8'hFF, 1'b1, 1'b1, "R3 max add");
    run8(8'h7F, 8'h01, 1'b0, 1'b1, "R5 positive overflow");
    run8(8'h80, 8'h80, 1'b0, 1'b1, "R5 negative overflow");
    run8(8'h7F, 8'h00, 1'b1, 1'b1, "R5 overflow via carry_in");
    run8(8'h05, 8'h03, 1'b1, 1'b0, "R2 plain difference");
    run8(8'h05, 8'h03, 1'b0, 1'b0, "R2 extra borrow");
    run8(8'h03, 8'h05, 1'b1, 1'b0, "R4 borrow");
    run8(8'h80, 8'h01, 1'b1, 1'b0, "R5 sub overflow");
    run8(8'h80, 8'h00, 1'b0, 1'b0, "R5 sub overflow via borrow");
    run8(8'h7F, 8'h80, 1'b1, 1'b0, "R5 pos minus neg");
    run8(8'h00, 8'h00, 1'b0, 1'b0, "R4 zero borrow in");

    // R6 equal operands in subtract mode
    run8(8'hA5, 8'hA5, 1'b1, 1'b0, "R6 equal cin1");
    cmp("R6 zero result", r8, 0);
    cmp("R6 no borrow", c8, 1);
    run8(8'hA5, 8'hA5, 1'b0, 1'b0, "R6 equal cin0");
    cmp("R6 all ones", r8, 255);
    cmp("R6 borrow", c8, 0);
    cmp("R6 no overflow", v8, 0);

    for (int i = 0; i < 3000; i++) begin
      run8(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), "random");
    end

    // R7 exhaustive narrow width
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            run4(4'(a), 4'(b), 1'(c), 1'(m));

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule